// File: doc/BRIEF.md
# PWM Dead-Band Delay Generator

This block sits between a PWM action stage and a chopper stage. It takes two PWM channels, A and B, and returns two outputs built from two internal delay paths. The rising path holds back each low-to-high transition of its source by a programmed number of clock cycles. The falling path does the same for high-to-low transitions. It is used to put guard time between the upper and lower switches of an inverter leg. It also supports asymmetric arrangements, such as one channel passed straight through while the other is delayed.

A six-bit control word sets three things. One field picks the source (A or B) for each delay path. A second field inverts either delayed path or both. A third field chooses, for each output, between the delayed path and the raw input. Two ten-bit registers hold the delay counts. All three registers sit behind a simple write port with a combinational read port.

Top module: `pwm_deadband`

## Requirements
- R1: After reset, the control word and both delay counts read as zero, and each output equals its raw input.
- R2: Register addresses are 0 for control, 1 for the rising count and 2 for the falling count; address 3 reads zero. The control word occupies bits 5:4 (source select), 3:2 (polarity) and 1:0 (output select). Control bits 15:6 and count bits 15:10 read as zero whatever was written.
- R3: With output select 0, output A equals input A and output B equals input B, whatever the source-select and polarity settings.
- R4: On the rising path, a low-to-high source transition appears at the path output exactly N cycles later, where N is the rising count. A high-to-low transition appears in the same cycle.
- R5: On the falling path, a high-to-low source transition appears exactly M cycles later, where M is the falling count. A low-to-high transition appears in the same cycle.
- R6: A count of zero makes its path transparent.
- R7: A source pulse whose width in cycles is at most the count of the delaying path produces no output pulse. A wider pulse produces an output pulse that is shorter by the count.
- R8: Source select 0 feeds A to both paths, 1 feeds B to the rising path and A to the falling path, 2 feeds A to the rising path and B to the falling path, and 3 feeds B to both paths.
- R9: Polarity bit 2 inverts the delayed path driving output A, and bit 3 inverts the delayed path driving output B. Polarity has no effect on an output that is in bypass.
- R10: Output select 1 passes raw A to output A and the falling path to output B. Output select 2 passes raw B to output B and the rising path to output A. Output select 3 drives output A from the rising path and output B from the falling path.
- R11: A count written while a delay is running does not change that delay. It applies from the next qualifying edge.
- R12: With control value 0x0B (source 0, polarity 2, output select 3), output B is the delayed complement of A, and the two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for both write and read |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for addr_i, combinational |
| pwm_a_i | input | 1 | Channel A from the action stage |
| pwm_b_i | input | 1 | Channel B from the action stage |
| pwm_a_o | output | 1 | Channel A toward the chopper |
| pwm_b_o | output | 1 | Channel B toward the chopper |

## Verification
Assertions check on every cycle that:
- bypass mirrors the inputs;
- output select 1 and 2 pass their raw channel through;
- the complementary setting never drives both outputs high;
- a control write lands in the register;
- each path holds its output back, or passes it through, on the cycle its source changes, according to whether the count is zero.

The bench scenarios cover what spans many cycles: the exact cycle at which a delayed edge emerges, pulse swallowing at and just past the count, source selection, polarity combinations, and a count rewritten mid-delay.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_RISE = 2'd1,
    ADDR_FALL = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  // packed MSB first: src_sel at 5:4, pol at 3:2, out_sel at 1:0
  typedef struct packed {
    logic [1:0] src_sel;
    logic [1:0] pol;
    logic [1:0] out_sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dbg_edge_delay.sv
module dbg_edge_delay #(
  parameter int CNT_W = 10,
  parameter bit RISE  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_i,
  input  logic [CNT_W-1:0] cfg_i,
  output logic             y_o
);
  // act: source sits at the level whose entry is delayed
  logic             act;
  logic [CNT_W-1:0] el_q;
  logic [CNT_W-1:0] lat_q;
  logic [CNT_W-1:0] lat_eff;
  logic             done;

  assign act = RISE ? src_i : ~src_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      el_q  <= '0;
      lat_q <= '0;
    end else begin
      if (!act)             el_q <= '0;
      else if (el_q != '1)  el_q <= el_q + 1'b1;
      // count is captured on the entry cycle, later writes wait for next edge
      if (act && el_q == '0) lat_q <= cfg_i;
    end
  end

  assign lat_eff = (el_q == '0) ? cfg_i : lat_q;
  assign done    = act && (el_q >= lat_eff);
  assign y_o     = RISE ? done : ~done;

  // R4
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && !$past(act) && cfg_i != '0) |-> (y_o == !RISE));
  // R6
  edge_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && !$past(act) && cfg_i == '0) |-> (y_o == RISE));
  // R4
  exit_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act && $past(act)) |-> (y_o == !RISE));
endmodule

// File: rtl/dbg_regs.sv
module dbg_regs
  import dbg_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  rise_cnt_o,
  output logic [CNT_W-1:0]  fall_cnt_o
);
  logic unused_wr_hi;
  assign unused_wr_hi = ^wr_data_i[DATA_W-1:CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o     <= '0;
      rise_cnt_o <= '0;
      fall_cnt_o <= '0;
    end else if (wr_en_i) begin
      case (reg_addr_e'(addr_i))
        ADDR_CTRL: ctrl_o     <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
        ADDR_RISE: rise_cnt_o <= wr_data_i[CNT_W-1:0];
        ADDR_FALL: fall_cnt_o <= wr_data_i[CNT_W-1:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (reg_addr_e'(addr_i))
      ADDR_CTRL: rd_data_o[CTRL_W-1:0] = ctrl_o;
      ADDR_RISE: rd_data_o[CNT_W-1:0]  = rise_cnt_o;
      ADDR_FALL: rd_data_o[CNT_W-1:0]  = fall_cnt_o;
      default:   rd_data_o = '0;
    endcase
  end

  // R2
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_CTRL) |=> (ctrl_o == $past(wr_data_i[CTRL_W-1:0])));
  // R11
  rise_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_RISE) |=> $stable(rise_cnt_o));
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
  import dbg_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              pwm_a_i,
  input  logic              pwm_b_i,
  output logic              pwm_a_o,
  output logic              pwm_b_o
);
  localparam int NPATH = 2;  // 0: rising path -> out A, 1: falling path -> out B

  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt   [NPATH];
  logic [NPATH-1:0] src;
  logic [NPATH-1:0] dly;
  logic [NPATH-1:0] path;

  dbg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .ctrl_o     (ctrl),
    .rise_cnt_o (cnt[0]),
    .fall_cnt_o (cnt[1])
  );

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    // src_sel bit g picks B for path g
    assign src[g] = ctrl.src_sel[g] ? pwm_b_i : pwm_a_i;

    dbg_edge_delay #(.CNT_W(CNT_W), .RISE(g == 0)) u_dly (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src[g]),
      .cfg_i  (cnt[g]),
      .y_o    (dly[g])
    );

    assign path[g] = dly[g] ^ ctrl.pol[g];
  end

  assign pwm_a_o = ctrl.out_sel[1] ? path[0] : pwm_a_i;
  assign pwm_b_o = ctrl.out_sel[0] ? path[1] : pwm_b_i;

  // R3
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.out_sel == 2'b00) |-> (pwm_a_o == pwm_a_i && pwm_b_o == pwm_b_i));
  // R10
  raw_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.out_sel == 2'b01) |-> (pwm_a_o == pwm_a_i));
  // R10
  raw_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.out_sel == 2'b10) |-> (pwm_b_o == pwm_b_i));
  // R12
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl == ctrl_t'(6'h0B)) |-> !(pwm_a_o && pwm_b_o));
endmodule

// File: tb/tb_pwm_deadband.sv
module tb_pwm_deadband;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        a_i = 1'b0, b_i = 1'b0;
  logic        a_o, b_o;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pwm_deadband dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(rdata),
    .pwm_a_i(a_i), .pwm_b_i(b_i), .pwm_a_o(a_o), .pwm_b_o(b_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic nx(); @(negedge clk); #1; endtask
  task automatic settle(); repeat (6) nx(); endtask

  task automatic wreg(logic [1:0] ad, logic [15:0] d);
    nx(); wr_en = 1'b1; addr = ad; wdata = d;
    nx(); wr_en = 1'b0;
  endtask

  task automatic rreg(logic [1:0] ad, logic [15:0] exp, string tag);
    addr = ad; #1; chk(tag, rdata, exp);
  endtask

  task automatic t_reset();
    rreg(2'd0, 16'h0, "R1 ctrl");
    rreg(2'd1, 16'h0, "R1 rise");
    rreg(2'd2, 16'h0, "R1 fall");
    a_i = 1'b1; b_i = 1'b0; #1;
    chk("R1 out", {a_o, b_o}, 2'b10);
    a_i = 1'b0; b_i = 1'b1; #1;
    chk("R1 out2", {a_o, b_o}, 2'b01);
    b_i = 1'b0;
  endtask

  task automatic t_regs();
    wreg(2'd0, 16'hFFFF); rreg(2'd0, 16'h003F, "R2 ctrl reserved");
    wreg(2'd1, 16'hFFFF); rreg(2'd1, 16'h03FF, "R2 rise width");
    wreg(2'd2, 16'h1234); rreg(2'd2, 16'h0234, "R2 fall width");
    wreg(2'd3, 16'hFFFF); rreg(2'd3, 16'h0000, "R2 addr3");
  endtask

  task automatic t_bypass();
    wreg(2'd1, 16'd3); wreg(2'd2, 16'd3); wreg(2'd0, 16'h003C); settle();
    for (int i = 0; i < 4; i++) begin
      a_i = i[0]; b_i = i[1]; #1;
      chk("R3 bypass", {a_o, b_o}, {a_i, b_i});
      nx();
    end
    a_i = 0; b_i = 0;
  endtask

  task automatic t_delays();
    wreg(2'd1, 16'd3); wreg(2'd2, 16'd2); wreg(2'd0, 16'h0003); settle();
    a_i = 1'b1; #1;
    for (int k = 0; k <= 4; k++) begin
      chk("R4 rise delay", a_o, k >= 3);
      chk("R5 fall path rise passes", b_o, 1'b1);
      nx();
    end
    a_i = 1'b0; #1;
    for (int k = 0; k <= 3; k++) begin
      chk("R4 rise path fall passes", a_o, 1'b0);
      chk("R5 fall delay", b_o, k < 2);
      nx();
    end
  endtask

  task automatic t_zero();
    wreg(2'd1, 16'd0); wreg(2'd2, 16'd0); wreg(2'd0, 16'h0003); settle();
    for (int i = 0; i < 4; i++) begin
      a_i = i[0]; #1;
      chk("R6 transparent", {a_o, b_o}, {a_i, a_i});
      nx();
    end
    a_i = 0;
  endtask

  task automatic t_swallow();
    int hi;
    wreg(2'd1, 16'd4); wreg(2'd0, 16'h0003); settle();
    hi = 0;
    a_i = 1'b1; #1;
    for (int k = 0; k < 4; k++) begin hi += a_o; nx(); end
    a_i = 1'b0; settle();
    chk("R7 swallowed pulse", hi, 0);
    hi = 0;
    a_i = 1'b1; #1;
    for (int k = 0; k < 5; k++) begin
      if (a_o) chk("R7 wide pulse cycle", k, 4);
      hi += a_o; nx();
    end
    a_i = 1'b0; settle();
    chk("R7 wide pulse width", hi, 1);
  endtask

  task automatic t_src();
    wreg(2'd1, 16'd2); wreg(2'd2, 16'd2); wreg(2'd0, 16'h0013); settle();
    b_i = 1'b1; #1;
    for (int k = 0; k <= 3; k++) begin
      chk("R8 mode1 rise from B", a_o, k >= 2);
      chk("R8 mode1 fall from A", b_o, 1'b0);
      nx();
    end
    wreg(2'd0, 16'h0023); settle();
    chk("R8 mode2 rise from A", a_o, 1'b0);
    b_i = 1'b0; #1;
    for (int k = 0; k <= 3; k++) begin
      chk("R8 mode2 fall from B", b_o, k < 2);
      nx();
    end
    wreg(2'd0, 16'h0033); settle();
    b_i = 1'b1; #1;
    nx(); nx();
    chk("R8 mode3 both from B", {a_o, b_o}, 2'b11);
    b_i = 1'b0; settle();
  endtask

  task automatic t_pol();
    wreg(2'd1, 16'd0); wreg(2'd2, 16'd0);
    a_i = 1'b1;
    wreg(2'd0, 16'h0007); settle();
    chk("R9 pol1", {a_o, b_o}, 2'b01);
    wreg(2'd0, 16'h000B); settle();
    chk("R9 pol2", {a_o, b_o}, 2'b10);
    wreg(2'd0, 16'h000F); settle();
    chk("R9 pol3 high", {a_o, b_o}, 2'b00);
    a_i = 1'b0; #1;
    chk("R9 pol3 low", {a_o, b_o}, 2'b11);
    // bypassed output stays uninverted
    wreg(2'd0, 16'h000D); settle();
    chk("R9 pol on bypassed A", a_o, 1'b0);
  endtask

  task automatic t_outsel();
    wreg(2'd1, 16'd2); wreg(2'd2, 16'd2); wreg(2'd0, 16'h0001); settle();
    a_i = 1'b1; #1;
    chk("R10 mode1 raw A", {a_o, b_o}, 2'b11);
    nx(); nx();
    a_i = 1'b0; #1;
    for (int k = 0; k <= 2; k++) begin
      chk("R10 mode1 A raw", a_o, 1'b0);
      chk("R10 mode1 B falling", b_o, k < 2);
      nx();
    end
    wreg(2'd0, 16'h0002); settle();
    b_i = 1'b1; #1;
    chk("R10 mode2 raw B", b_o, 1'b1);
    a_i = 1'b1; #1;
    for (int k = 0; k <= 2; k++) begin
      chk("R10 mode2 A rising", a_o, k >= 2);
      nx();
    end
    a_i = 0; b_i = 0; settle();
  endtask

  task automatic t_midchange();
    wreg(2'd1, 16'd5); wreg(2'd0, 16'h0003); settle();
    a_i = 1'b1; #1;
    for (int k = 0; k <= 6; k++) begin
      chk("R11 old count kept", a_o, k >= 5);
      nx();
      if (k == 0) begin wr_en = 1'b1; addr = 2'd1; wdata = 16'd1; end
      if (k == 1) wr_en = 1'b0;
    end
    a_i = 1'b0; settle();
    a_i = 1'b1; #1;
    for (int k = 0; k <= 2; k++) begin
      chk("R11 new count next edge", a_o, k >= 1);
      nx();
    end
    a_i = 1'b0; settle();
  endtask

  task automatic t_classic();
    wreg(2'd1, 16'd2); wreg(2'd2, 16'd3); wreg(2'd0, 16'h000B); settle();
    chk("R12 idle", {a_o, b_o}, 2'b01);
    a_i = 1'b1; #1;
    for (int k = 0; k <= 3; k++) begin
      chk("R12 A rise delayed", a_o, k >= 2);
      chk("R12 B off at once", b_o, 1'b0);
      nx();
    end
    a_i = 1'b0; #1;
    for (int k = 0; k <= 4; k++) begin
      chk("R12 A off at once", a_o, 1'b0);
      chk("R12 B on delayed", b_o, k >= 3);
      nx();
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nx();
    t_reset();
    t_regs();
    t_bypass();
    t_delays();
    t_zero();
    t_swallow();
    t_src();
    t_pol();
    t_outsel();
    t_midchange();
    t_classic();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule